// File: doc/BRIEF.md
# Two-Port Address Window Steering Filter

This block sits on the miss path of a cache. It sends each outgoing physical address request to one of two downstream master ports. A programmable window, kept at 1 MiB granularity, selects the memory-controller port M1. Every address outside the window, and every address while the filter is switched off, goes to the interconnect port M0. The routing decision is combinational, so a request reaches its port in the same cycle it is presented upstream.

Two configuration words are reachable through a small register port: the window's lower bound together with an enable flag, and the window's exclusive upper bound. Only the top twelve address bits of each bound are stored. A write that carries bits below the 1 MiB boundary is refused rather than truncated, and the refusal is reported on an error pulse. One common use is to clear the lower bound to zero while keeping the upper bound, so that the lowest megabyte is served by the memory controller.

Top module: `mport_addr_steer`

## Requirements
- R1: After reset, offset 0xC00 reads 0x0010_0001 (lower bound 0x001 in bits [31:20], enable flag in bit 0 set) and offset 0xC04 reads 0xC000_0000.
- R2: Offset 0xC00 returns the lower bound in bits [31:20], the enable flag in bit 0 and zero in bits [19:1]; offset 0xC04 returns the upper bound in bits [31:20] and zero in bits [19:0]; an accepted write is visible on the read data from the next cycle.
- R3: With the enable flag set, a request whose address bits [31:20] satisfy lower <= a < upper drives m1_valid, and any other request drives m0_valid, in the same cycle as up_valid.
- R4: With the enable flag clear, every request goes to M0 and m1_valid stays low.
- R5: A write to 0xC00 with any of bits [19:1] set, or to 0xC04 with any of bits [19:0] set, changes no stored value and raises cfg_err for exactly the one cycle after the write edge; accepted writes leave cfg_err low.
- R6: At most one of m0_valid and m1_valid is high, neither is high without up_valid, up_ready equals the ready of the selected port, and up_addr is passed unchanged to both ports.
- R7: When the lower bound is not below the upper bound, the window is empty and every request goes to M0.
- R8: With the lower bound written as zero and the upper bound kept, addresses in the lowest 1 MiB go to M1.
- R9: A write to any offset other than 0xC00 and 0xC04 changes no stored value and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted by the selected port |
| up_addr | input | 32 | Upstream physical address |
| m0_valid | output | 1 | Interconnect port request valid |
| m0_ready | input | 1 | Interconnect port ready |
| m0_addr | output | 32 | Interconnect port address |
| m1_valid | output | 1 | Memory-controller port request valid |
| m1_ready | input | 1 | Memory-controller port ready |
| m1_addr | output | 32 | Memory-controller port address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration register offset for write and read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| cfg_err | output | 1 | One-cycle pulse after a refused write |

## Verification
Every one of the 4096 values of the top twelve address bits is presented under several settings: the reset window, an arbitrary interior window, the same window with the filter off, two empty windows (equal bounds and inverted bounds), a window starting at zero, and a window reaching the top value. The interior window separates an off-by-one on either bound from a correct compare. The empty and disabled cases separate a missing enable or an unsigned-order slip from correct gating. The low bits of the address and both ready inputs vary with the sweep index, so address forwarding and ready selection are checked for each port. Refused writes to each register and writes to an unused offset are followed by read-back, to show that nothing stored has changed.

// File: rtl/afl_pkg.sv
package afl_pkg;
    localparam int ADDR_W   = 32;
    localparam int GRAN_LSB = 20;
    localparam int BOUND_W  = ADDR_W - GRAN_LSB;
    localparam int REG_AW   = 12;
    localparam int NPORT    = 2;
    localparam int PSEL_W   = $clog2(NPORT);

    typedef logic [BOUND_W-1:0] bound_t;
    typedef logic [ADDR_W-1:0]  addr_t;

    typedef enum logic [PSEL_W-1:0] {
        PORT_XBAR = '0,
        PORT_MEMC = 1'b1
    } port_sel_e;

    typedef struct packed {
        bound_t lo;
        bound_t hi;
        logic   on;
    } window_t;

    function automatic bound_t top_bits(input addr_t a);
        return a[ADDR_W-1:GRAN_LSB];
    endfunction
endpackage

// File: rtl/afl_cfg_regs.sv
module afl_cfg_regs
    import afl_pkg::*;
#(
    parameter logic [REG_AW-1:0] LO_OFS = 12'hC00,
    parameter logic [REG_AW-1:0] HI_OFS = 12'hC04,
    parameter bound_t LO_RST = 12'h001,
    parameter bound_t HI_RST = 12'hC00,
    parameter logic   ON_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  addr_t             wdata,
    output addr_t             rdata,
    output logic              err,
    output window_t           win
);
    logic hit_lo, hit_hi, bad_lo, bad_hi, refuse;

    assign hit_lo = (addr == LO_OFS);
    assign hit_hi = (addr == HI_OFS);
    // Bit 0 of the lower-bound word is the enable; bits between are reserved.
    assign bad_lo = |wdata[GRAN_LSB-1:1];
    assign bad_hi = |wdata[GRAN_LSB-1:0];
    assign refuse = we && ((hit_lo && bad_lo) || (hit_hi && bad_hi));

    always_ff @(posedge clk) begin
        if (rst) begin
            win.lo <= LO_RST;
            win.hi <= HI_RST;
            win.on <= ON_RST;
            err    <= 1'b0;
        end else begin
            err <= refuse;
            if (we && hit_lo && !bad_lo) begin
                win.lo <= top_bits(wdata);
                win.on <= wdata[0];
            end
            if (we && hit_hi && !bad_hi) begin
                win.hi <= top_bits(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_lo) begin
            rdata = {win.lo, {(GRAN_LSB-1){1'b0}}, win.on};
        end else if (hit_hi) begin
            rdata = {win.hi, {GRAN_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/afl_window_cmp.sv
module afl_window_cmp
    import afl_pkg::*;
(
    input  window_t   win,
    input  addr_t     addr,
    output port_sel_e sel
);
    bound_t key;
    logic   above_lo, below_hi;

    assign key      = top_bits(addr);
    assign above_lo = (key >= win.lo);
    assign below_hi = (key <  win.hi);
    assign sel      = (win.on && above_lo && below_hi) ? PORT_MEMC : PORT_XBAR;
endmodule

// File: rtl/afl_port_steer.sv
module afl_port_steer
    import afl_pkg::*;
(
    input  logic             in_valid,
    output logic             in_ready,
    input  addr_t            in_addr,
    input  port_sel_e        sel,
    output logic [NPORT-1:0] out_valid,
    input  logic [NPORT-1:0] out_ready,
    output addr_t            out_addr [NPORT]
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign out_valid[p] = in_valid && (sel == port_sel_e'(p));
        assign out_addr[p]  = in_addr;
    end

    assign in_ready = out_ready[sel];
endmodule

// File: rtl/mport_addr_steer.sv
module mport_addr_steer
    import afl_pkg::*;
#(
    parameter logic [REG_AW-1:0] LO_OFS = 12'hC00,
    parameter logic [REG_AW-1:0] HI_OFS = 12'hC04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    output logic              m0_valid,
    input  logic              m0_ready,
    output logic [ADDR_W-1:0] m0_addr,
    output logic              m1_valid,
    input  logic              m1_ready,
    output logic [ADDR_W-1:0] m1_addr,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              cfg_err
);
    window_t          win;
    port_sel_e        sel;
    logic [NPORT-1:0] pv, pr;
    addr_t            pa [NPORT];
    logic             win_on;

    afl_cfg_regs #(.LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .err(cfg_err), .win(win)
    );

    afl_window_cmp u_cmp (.win(win), .addr(up_addr), .sel(sel));

    assign pr = {m1_ready, m0_ready};

    afl_port_steer u_steer (
        .in_valid(up_valid), .in_ready(up_ready), .in_addr(up_addr),
        .sel(sel), .out_valid(pv), .out_ready(pr), .out_addr(pa)
    );

    assign m0_valid = pv[PORT_XBAR];
    assign m1_valid = pv[PORT_MEMC];
    assign m0_addr  = pa[PORT_XBAR];
    assign m1_addr  = pa[PORT_MEMC];
    assign win_on   = win.on;
endmodule

// File: rtl/afl_chk.sv
module afl_chk
    import afl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_ready,
    input logic [ADDR_W-1:0] up_addr,
    input logic              m0_valid,
    input logic              m0_ready,
    input logic [ADDR_W-1:0] m0_addr,
    input logic              m1_valid,
    input logic              m1_ready,
    input logic [ADDR_W-1:0] m1_addr,
    input logic              cfg_we,
    input logic              cfg_err,
    input logic              win_on
);
    // R6
    excl_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(m0_valid && m1_valid));
    // R6
    req_lands_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid |-> (m0_valid || m1_valid));
    // R6
    ready_m1_chk: assert property (@(posedge clk) disable iff (rst)
        m1_valid |-> (up_ready == m1_ready));
    // R6
    ready_m0_chk: assert property (@(posedge clk) disable iff (rst)
        m0_valid |-> (up_ready == m0_ready));
    // R6
    addr_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid |-> (m0_addr == up_addr && m1_addr == up_addr));
    // R4
    off_no_m1_chk: assert property (@(posedge clk) disable iff (rst)
        !win_on |-> !m1_valid);
    // R5
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(cfg_we));
    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !$past(cfg_we, 1) ) |-> 1'b0 );
endmodule

bind mport_addr_steer afl_chk u_chk (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .m0_valid(m0_valid), .m0_ready(m0_ready),
    .m0_addr(m0_addr), .m1_valid(m1_valid), .m1_ready(m1_ready),
    .m1_addr(m1_addr), .cfg_we(cfg_we), .cfg_err(cfg_err), .win_on(win_on)
);

// File: tb/tb_mport_addr_steer.sv
`timescale 1ns/1ps
module tb_mport_addr_steer;
    logic        clk = 1'b0;
    logic        rst;
    logic        up_valid, up_ready, m0_valid, m0_ready, m1_valid, m1_ready;
    logic [31:0] up_addr, m0_addr, m1_addr;
    logic        cfg_we, cfg_err;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    mport_addr_steer dut (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
        .up_addr(up_addr), .m0_valid(m0_valid), .m0_ready(m0_ready),
        .m0_addr(m0_addr), .m1_valid(m1_valid), .m1_ready(m1_ready),
        .m1_addr(m1_addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [11:0] ofs, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = ofs;
        #0.5;
        check(cfg_rdata === exp, req, cfg_rdata, exp);
    endtask

    // Write, then check the error pulse after the edge and its drop one cycle later.
    task automatic write_chk(input logic [11:0] ofs, input logic [31:0] data,
                             input bit exp_err, input string req);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_err === exp_err, req, {31'd0, cfg_err}, {31'd0, exp_err});
        @(negedge clk);
        check(cfg_err === 1'b0, req, {31'd0, cfg_err}, 32'd0);
    endtask

    task automatic sweep(input logic [11:0] lo, input logic [11:0] hi, input bit on,
                         input string req);
        for (int i = 0; i < 4096; i++) begin
            logic [31:0] a;
            bit          to_m1, r0, r1, exp_rdy;
            a  = {i[11:0], 20'(i * 40503 + 7)};
            r0 = i[0];
            r1 = i[1];
            to_m1   = on && (i[11:0] >= lo) && (i[11:0] < hi);
            exp_rdy = to_m1 ? r1 : r0;
            @(negedge clk);
            up_valid = (i % 17) != 5;
            up_addr  = a; m0_ready = r0; m1_ready = r1;
            #0.5;
            if (up_valid) begin
                check(m1_valid === to_m1 && m0_valid === !to_m1, req,
                      {30'd0, m1_valid, m0_valid}, {30'd0, to_m1, !to_m1});
                check(up_ready === exp_rdy && m0_addr === a && m1_addr === a,
                      "R6 ready/addr", m1_valid ? m1_addr : m0_addr, a);
            end else begin
                check(!m0_valid && !m1_valid, "R6 idle",
                      {30'd0, m1_valid, m0_valid}, 32'd0);
            end
        end
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; up_valid = 1'b0; up_addr = '0; m0_ready = 1'b0; m1_ready = 1'b0;
        cfg_we = 1'b0; cfg_addr = 12'hC00; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values, R2 zero low bits
        read_chk(12'hC00, 32'h0010_0001, "R1 lo reset");
        read_chk(12'hC04, 32'hC000_0000, "R1 hi reset");
        check(cfg_err === 1'b0, "R1 err reset", {31'd0, cfg_err}, 32'd0);
        sweep(12'h001, 12'hC00, 1'b1, "R3 reset window");
        // R2 interior window
        write_chk(12'hC00, 32'h1230_0001, 1'b0, "R5 accepted lo");
        write_chk(12'hC04, 32'h4560_0000, 1'b0, "R5 accepted hi");
        read_chk(12'hC00, 32'h1230_0001, "R2 lo readback");
        read_chk(12'hC04, 32'h4560_0000, "R2 hi readback");
        sweep(12'h123, 12'h456, 1'b1, "R3 interior window");
        // R5 refused writes
        write_chk(12'hC00, 32'h7770_0011, 1'b1, "R5 bad lo err");
        write_chk(12'hC00, 32'h7778_0001, 1'b1, "R5 bad lo bit19 err");
        write_chk(12'hC04, 32'h8880_0001, 1'b1, "R5 bad hi bit0 err");
        read_chk(12'hC00, 32'h1230_0001, "R5 lo unchanged");
        read_chk(12'hC04, 32'h4560_0000, "R5 hi unchanged");
        // R9 other offset
        write_chk(12'hC08, 32'h0000_0000, 1'b0, "R9 no err");
        write_chk(12'h000, 32'hFFF0_0000, 1'b0, "R9 no err 0");
        read_chk(12'hC00, 32'h1230_0001, "R9 lo unchanged");
        read_chk(12'hC04, 32'h4560_0000, "R9 hi unchanged");
        read_chk(12'hC08, 32'h0000_0000, "R2 unused reads zero");
        // R4 disabled
        write_chk(12'hC00, 32'h1230_0000, 1'b0, "R4 disable write");
        read_chk(12'hC00, 32'h1230_0000, "R4 lo readback");
        sweep(12'h123, 12'h456, 1'b0, "R4 disabled");
        // R7 empty windows
        write_chk(12'hC00, 32'h8000_0001, 1'b0, "R7 write");
        write_chk(12'hC04, 32'h8000_0000, 1'b0, "R7 write");
        sweep(12'h800, 12'h800, 1'b1, "R7 equal bounds");
        write_chk(12'hC00, 32'h9000_0001, 1'b0, "R7 write");
        write_chk(12'hC04, 32'h1000_0000, 1'b0, "R7 write");
        sweep(12'h900, 12'h100, 1'b1, "R7 inverted bounds");
        // R8 zero lower bound keeping upper bound
        write_chk(12'hC04, 32'hC000_0000, 1'b0, "R8 hi");
        write_chk(12'hC00, 32'h0000_0001, 1'b0, "R8 lo zero");
        read_chk(12'hC00, 32'h0000_0001, "R8 lo readback");
        sweep(12'h000, 12'hC00, 1'b1, "R8 low MiB to M1");
        // R3 top bound
        write_chk(12'hC04, 32'hFFF0_0000, 1'b0, "R3 hi top");
        sweep(12'h000, 12'hFFF, 1'b1, "R3 full window");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule